// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block turns the peripheral clock into the 16x oversampling enable for a UART. It divides the clock by a 16-bit integer divisor. It can also stretch that divisor by a fractional factor of 1 + A/M, where A is the add step and M is the modulus. This reaches division ratios that are not whole numbers, so the resulting rate is clk / (16 × divisor × (1 + A/M)).

The stretch works by pulse swallowing. Each time the integer period ends, a small accumulator adds A. Whenever the sum reaches M, M is taken off and the next period is twice the divisor long. The block emits a one-cycle pulse at the end of every period. The periods therefore vary slightly, but the average period is exact.

Software reaches the block through a small byte-wide register port:

| Address | With the latch-access bit clear | With the latch-access bit set |
|---|---|---|
| 0 | Belongs to neighbouring logic | Divisor low byte |
| 1 | Belongs to neighbouring logic | Divisor high byte |
| 2 | Fractional register | Fractional register |
| 3 | Line control register | Line control register |

The latch-access bit is bit 7 of the line control register. The host chooses the divisor and the fractional pair for each baud rate; this block does not compute them.

Top module: `baudgen_top`

## Requirements
- R1: With the fractional stretch off, `tick_o` is high for exactly one cycle once every D clock cycles, where D is the divisor.
- R2: With a valid fractional pair (1 ≤ M ≤ 15, A < M), every period starts by adding A to an accumulator. If the sum is at least M, M is subtracted and that period lasts 2×D cycles; otherwise the sum is kept and the period lasts D cycles. The accumulator starts at 0 after a restart.
- R3: Over any M consecutive periods after a restart with a valid pair, the total is exactly D×(M + A) cycles.
- R4: A divisor value of 0 behaves as a divisor of 1.
- R5: If M = 0 or A ≥ M, the stretch is off and the block divides by D alone. A = 0 with M = 1 gives the same plain divide.
- R6: A write that changes a divisor byte or the fractional register restarts the counting. The first tick arrives exactly L cycles after the write's clock edge, where L is the first period length, and no tick from the old setting comes in between.
- R7: The divisor bytes at address 0 (low) and address 1 (high) can be written and read only while bit 7 of the line control register at address 3 is set. A write to address 0 or 1 with that bit clear changes neither the divisor nor the tick phase, and a read of those addresses then returns 0.
- R8: The fractional register at address 2 holds A in bits 3:0 and M in bits 7:4. It and the line control register at address 3 read back the value last written.
- R9: Reset is synchronous and active low. While it is held, `tick_o` is 0. Reset leaves the divisor at 1, the fractional register at 0x10 and the line control register at 0x00, so ticks then come on every cycle.
- R10: A write to the line control register does not restart the tick counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| tick_o | output | 1 | One-cycle 16x oversampling enable |

## Verification
The bench builds the block with its default parameters: a 16-bit divisor and a 4-bit fractional field.

At this width every legal fractional pair can be reached, and so can the invalid ones where A is at least M or M is 0. The full accumulator cycle also completes within 15 periods.

Divisors drawn at random stay small so that many complete cycles fit in a short run. One directed case sets the high byte to show that both divisor bytes feed the period.

// File: rtl/baudgen_pkg.sv
// Package: shared constants for the fractional baud tick generator.
// Assumes a byte-wide register port with four addresses.
package baudgen_pkg;
    localparam int BYTE_W  = 8;
    localparam int ADDR_W  = 2;
    localparam int FRAC_W  = 4;
    localparam int DIV_W   = 2 * BYTE_W;
    localparam int LATCH_BIT = 7;

    localparam logic [ADDR_W-1:0] ADR_DIV_LO = 2'd0;
    localparam logic [ADDR_W-1:0] ADR_DIV_HI = 2'd1;
    localparam logic [ADDR_W-1:0] ADR_FRAC   = 2'd2;
    localparam logic [ADDR_W-1:0] ADR_LINE   = 2'd3;

    localparam logic [BYTE_W-1:0] RST_DIV_LO = 8'h01;
    localparam logic [BYTE_W-1:0] RST_DIV_HI = 8'h00;
    localparam logic [BYTE_W-1:0] RST_FRAC   = 8'h10;
    localparam logic [BYTE_W-1:0] RST_LINE   = 8'h00;
endpackage

// File: rtl/baudgen_regs.sv
// Module: register file for the divisor bytes, fractional pair and line control.
// The divisor bytes are writable and readable only while the latch bit is set.
// The cfg_* outputs carry the values that hold after the current edge, so a
// restart sees the new setting in the same cycle as its write.
module baudgen_regs
    import baudgen_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    output logic [DIV_W-1:0]  cfg_div,
    output logic [FRAC_W-1:0] cfg_add,
    output logic [FRAC_W-1:0] cfg_mod,
    output logic              restart_o
);
    logic [BYTE_W-1:0] lo_q, hi_q, frac_q, line_q;
    logic [BYTE_W-1:0] lo_d, hi_d, frac_d;
    logic wr_lo, wr_hi, wr_frac, wr_line, latch;

    assign latch = line_q[LATCH_BIT];

    // Decode which register the current write targets.
    always_comb begin
        wr_lo   = wr_en && (addr == ADR_DIV_LO) && latch;
        wr_hi   = wr_en && (addr == ADR_DIV_HI) && latch;
        wr_frac = wr_en && (addr == ADR_FRAC);
        wr_line = wr_en && (addr == ADR_LINE);
    end

    // Next-state values, exported as the live configuration.
    always_comb begin
        lo_d   = wr_lo   ? wdata : lo_q;
        hi_d   = wr_hi   ? wdata : hi_q;
        frac_d = wr_frac ? wdata : frac_q;
    end

    assign cfg_div   = {hi_d, lo_d};
    assign cfg_add   = frac_d[FRAC_W-1:0];
    assign cfg_mod   = frac_d[BYTE_W-1:FRAC_W];
    assign restart_o = wr_lo || wr_hi || wr_frac;

    // Register storage with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q   <= RST_DIV_LO;
            hi_q   <= RST_DIV_HI;
            frac_q <= RST_FRAC;
            line_q <= RST_LINE;
        end else begin
            lo_q   <= lo_d;
            hi_q   <= hi_d;
            frac_q <= frac_d;
            if (wr_line) line_q <= wdata;
        end
    end

    // Read mux; divisor bytes read as zero while the latch bit is clear.
    always_comb begin
        unique case (addr)
            ADR_DIV_LO: rdata = latch ? lo_q : '0;
            ADR_DIV_HI: rdata = latch ? hi_q : '0;
            ADR_FRAC:   rdata = frac_q;
            default:    rdata = line_q;
        endcase
    end

    // R7
    gated_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADR_DIV_LO && !latch) |=> $stable(lo_q));
    // R7
    gated_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADR_DIV_HI && !latch) |=> $stable(hi_q));
endmodule

// File: rtl/baudgen_frac.sv
// Module: fractional accumulator that decides which periods are doubled.
// It steps on restart or at the end of each period, and a restart starts
// from zero. The pair is treated as off when mod is 0 or add >= mod.
module baudgen_frac
    import baudgen_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              advance,
    input  logic [FRAC_W-1:0] add,
    input  logic [FRAC_W-1:0] modv,
    output logic              stretch_o
);
    logic [FRAC_W-1:0] acc_q, acc_d, base;
    logic [FRAC_W:0]   sum;
    logic              valid;

    // Sum for the period being loaded, and the resulting remainder.
    always_comb begin
        valid     = (modv != '0) && (add < modv);
        base      = restart ? '0 : acc_q;
        sum       = {1'b0, base} + {1'b0, add};
        stretch_o = valid && (sum >= {1'b0, modv});
        if (!valid)         acc_d = '0;
        else if (stretch_o) acc_d = FRAC_W'(sum - {1'b0, modv});
        else                acc_d = sum[FRAC_W-1:0];
    end

    // Accumulator register.
    always_ff @(posedge clk) begin
        if (!rst_n)                acc_q <= '0;
        else if (restart || advance) acc_q <= acc_d;
    end

    // R2
    acc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !restart) |-> (acc_q < modv));
endmodule

// File: rtl/baudgen_count.sv
// Module: period down-counter that emits the tick.
// Each period lasts D or 2*D cycles, with a divisor of 0 taken as 1.
// A restart reloads the counter and holds back the tick.
module baudgen_count
    import baudgen_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             stretch,
    input  logic [DIV_W-1:0] div,
    output logic             advance_o,
    output logic             tick_o
);
    logic [DIV_W:0]   cnt_q, len;
    logic [DIV_W-1:0] eff;
    logic             load;

    // Effective divisor and length of the period about to start.
    always_comb begin
        eff  = (div == '0) ? DIV_W'(1) : div;
        len  = stretch ? {eff, 1'b0} : {1'b0, eff};
        load = restart || (cnt_q == '0);
    end

    assign advance_o = (cnt_q == '0);

    // Count down; reload and tick at the end of each period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            tick_o <= 1'b0;
        end else if (load) begin
            cnt_q  <= len - 1'b1;
            tick_o <= !restart;
        end else begin
            cnt_q  <= cnt_q - 1'b1;
            tick_o <= 1'b0;
        end
    end

    // R6
    restart_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !tick_o);
    // R1
    tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && eff > DIV_W'(1)) |=> !tick_o);
    // R2
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !restart |-> (cnt_q < {eff, 1'b0}));
endmodule

// File: rtl/baudgen_top.sv
// Module: fractional baud tick generator top.
// Joins the register file, the accumulator and the period counter.
// Assumes a single clock domain with a synchronous active-low reset.
module baudgen_top
    import baudgen_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    output logic              tick_o
);
    logic [DIV_W-1:0]  cfg_div;
    logic [FRAC_W-1:0] cfg_add, cfg_mod;
    logic              restart, stretch, advance;

    baudgen_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .cfg_div(cfg_div),
        .cfg_add(cfg_add), .cfg_mod(cfg_mod), .restart_o(restart)
    );

    baudgen_frac u_frac (
        .clk(clk), .rst_n(rst_n), .restart(restart), .advance(advance),
        .add(cfg_add), .modv(cfg_mod), .stretch_o(stretch)
    );

    baudgen_count u_count (
        .clk(clk), .rst_n(rst_n), .restart(restart), .stretch(stretch),
        .div(cfg_div), .advance_o(advance), .tick_o(tick_o)
    );
endmodule

// File: tb/sim_baudgen_top.sv
`timescale 1ns/1ps
module sim_baudgen_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr_en = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       tick_o;

    int n_chk = 0;
    int n_fail = 0;
    int m_acc = 0;

    always #5 clk = ~clk;

    baudgen_top u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tick_o(tick_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected length of the next period, from the accumulator rule (R2, R4, R5).
    function automatic int exp_gap(input int dl, input int a, input int m);
        int eff = (dl == 0) ? 1 : dl;
        int s;
        if (m == 0 || a >= m) return eff;
        s = m_acc + a;
        if (s >= m) begin m_acc = s - m; return 2 * eff; end
        m_acc = s;
        return eff;
    endfunction

    // All tasks start and end just after a falling edge.
    task automatic wr(input int a, input int d);
        reg_wr_en = 1'b1; reg_addr = 2'(a); reg_wdata = 8'(d);
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output int v);
        reg_addr = 2'(a);
        #1 v = int'(reg_rdata);
    endtask

    task automatic wait_tick(output int n);
        n = 0;
        do begin
            @(posedge clk); n++;
            @(negedge clk);
        end while (!tick_o && n < 3000);
    endtask

    // Full setup; the fractional write comes last and restarts the counter.
    task automatic configure(input int dl, input int a, input int m);
        wr(3, 8'h80); wr(0, dl & 8'hFF); wr(1, (dl >> 8) & 8'hFF);
        wr(3, 8'h00); wr(2, (m << 4) | a);
        m_acc = 0;
    endtask

    task automatic run_gaps(input int dl, input int a, input int m, input int ng, input string req);
        int g, e, tot, etot, eff;
        tot = 0; etot = 0;
        eff = (dl == 0) ? 1 : dl;
        for (int k = 0; k < ng; k++) begin
            wait_tick(g);
            e = exp_gap(dl, a, m);
            check(g == e, req, g, e);
            if (k < m) begin tot += g; etot += e; end
        end
        if (m != 0 && a < m && ng >= m)
            check(tot == eff * (m + a), "R3", tot, eff * (m + a));
    endtask

    initial begin
        int v, g, dl, a, m;
        void'($urandom(1234));
        @(negedge clk); @(negedge clk);
        check(tick_o == 1'b0, "R9 tick in reset", tick_o, 0);
        rst_n = 1'b1;
        rd(2, v); check(v == 8'h10, "R9 frac reset", v, 8'h10);
        rd(3, v); check(v == 8'h00, "R9 line reset", v, 0);
        rd(0, v); check(v == 0, "R7 lo hidden", v, 0);
        wait_tick(g); wait_tick(g);
        check(g == 1, "R9 divisor 1 after reset", g, 1);

        // R8 field readback with latch set
        wr(3, 8'h80);
        rd(3, v); check(v == 8'h80, "R8 line readback", v, 8'h80);
        rd(0, v); check(v == 1, "R8 lo readback", v, 1);

        // R1 plain divide
        configure(7, 0, 1); run_gaps(7, 0, 1, 4, "R1");
        // R2 stretch, A=3 M=5
        configure(4, 3, 5); run_gaps(4, 3, 5, 11, "R2");
        rd(2, v); check(v == 8'h53, "R8 frac fields", v, 8'h53);
        // R4 divisor zero
        configure(0, 0, 1); run_gaps(0, 0, 1, 4, "R4");
        configure(0, 1, 2); run_gaps(0, 1, 2, 4, "R4 stretched");
        // R5 invalid pairs
        configure(6, 3, 0); run_gaps(6, 3, 0, 3, "R5 mod zero");
        configure(6, 7, 5); run_gaps(6, 7, 5, 3, "R5 add>=mod");
        // high byte participates
        configure(259, 1, 2); run_gaps(259, 1, 2, 3, "R1 high byte");

        // R7: write to address 0 with latch clear leaves phase and value alone
        configure(5, 0, 1);
        wait_tick(g);
        wr(0, 8'h33);
        wait_tick(g); check(g == 4, "R7 no restart", g, 4);
        wait_tick(g); check(g == 5, "R7 divisor kept", g, 5);
        rd(0, v); check(v == 0, "R7 read hidden", v, 0);
        // R10: line control write keeps the phase
        wr(3, 8'h80);
        wait_tick(g); check(g == 4, "R10 no restart", g, 4);
        rd(0, v); check(v == 5, "R7 lo value kept", v, 5);
        wr(3, 8'h00);
        // R6: mid-period fractional write restarts, first tick one full period later
        configure(9, 0, 1);
        wait_tick(g);
        repeat (3) @(negedge clk);
        wr(2, 8'h10);
        wait_tick(g); check(g == 9, "R6 restart from fractional write", g, 9);
        // R6: divisor write restarts with the new divisor
        wait_tick(g);
        wr(3, 8'h80);
        repeat (2) @(negedge clk);
        wr(0, 3);
        wait_tick(g); check(g == 3, "R6 restart from divisor write", g, 3);
        wr(3, 8'h00);

        // Constrained random settings
        for (int i = 0; i < 12; i++) begin
            dl = ($urandom % 8 == 0) ? 0 : 1 + ($urandom % 20);
            m  = $urandom % 16;
            a  = ($urandom % 6 == 0) ? ($urandom % 16) : ((m > 0) ? $urandom % m : 0);
            configure(dl, a, m);
            run_gaps(dl, a, m, (m > 0) ? m + 2 : 3, "R2 random");
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #2000000;
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule